// File: doc/BRIEF.md
# Chainable Double-Word Funnel Shifter

This block is a purely combinational shifter for multi-word integers. It takes a data word A and moves it left or right by an amount taken from the low six bits of a shift-source word B. The bit positions that the shift empties are filled from a separate fill word C. The bits pushed out of A are not lost. They come back on a second output, the spill word, with every other bit of that word cleared.

Because of this, a long integer stored as a sequence of limbs can be shifted one limb at a time. The spill word of each limb becomes the fill word of the next one, and no extra masking steps are needed between limbs. For a left shift the limbs are taken from least significant upward. For a right shift they are taken from most significant downward.

An optional record mode produces a 4-bit condition field. Three of its bits give the sign class of the result word, and one bit flags a nonzero spill. When record mode is off the field is all zeros. The block holds no state, so there are no states or transitions to list. The data path has three stages: a shared rotator, a mask generator and a merge stage with condition logic.

Top module: `dw_funnel_shift`

## Requirements
- R1: The shift amount n is b_word[5:0] (0 to 63). Bits b_word[63:6] have no effect on any output.
- R2: With dir_right = 0 (left), res_word equals a_word shifted left by n, and its n least-significant bits are the n least-significant bits of c_fill.
- R3: With dir_right = 0, spill_word holds the n most-significant bits of a_word in its n least-significant positions, and its other bits are zero.
- R4: With dir_right = 1 (right), res_word equals a_word shifted right by n, and its n most-significant bits are the n most-significant bits of c_fill.
- R5: With dir_right = 1, spill_word holds the n least-significant bits of a_word in its n most-significant positions, and its other bits are zero.
- R6: When n = 0, res_word equals a_word and spill_word is zero in both directions, whatever c_fill holds.
- R7: When rec_en = 1, cond[0] (overflow) is 1 exactly when spill_word is nonzero.
- R8: When rec_en = 1, cond[3] (less than zero), cond[2] (greater than zero) and cond[1] (equal to zero) come from a signed compare of res_word with zero. Exactly one of the three is set.
- R9: When rec_en = 0, cond is 4'b0000.
- R10: Feeding each limb's spill_word into the next limb's c_fill shifts a multi-limb integer exactly, with the final spill holding the bits shifted out of the whole integer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dir_right | input | 1 | 0 = shift left, 1 = shift right |
| a_word | input | 64 | Data word to be shifted |
| b_word | input | 64 | Shift source; only bits [5:0] are used |
| c_fill | input | 64 | Fill word supplying the vacated bit positions |
| rec_en | input | 1 | Enables the condition field |
| res_word | output | 64 | Shifted result with fill bits merged in |
| spill_word | output | 64 | Bits pushed out of a_word, other bits zero |
| cond | output | 4 | {LT, GT, EQ, OV} when rec_en = 1, else zero |

## Verification
Two functions can act on the same input vector: the fill merge that writes c_fill bits into res_word, and the spill path that returns the displaced bits of a_word. The overflow flag depends on the second function while the sign flags depend on the first. The bench provokes both at once with dense, nonzero a_word and c_fill patterns at mid-range and extreme shift amounts. Every output word and every condition bit is compared with values that the bench computes by 128-bit shifts of the concatenated words. Multi-limb chains in both directions are also checked against a 192-bit reference shift, which judges both paths together across limb boundaries.

// File: rtl/dw_funnel_pkg.sv
package dw_funnel_pkg;

    typedef enum logic {
        SHIFT_LEFT  = 1'b0,
        SHIFT_RIGHT = 1'b1
    } shift_dir_e;

    // condition field, most significant member first
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic ov;
    } cond_fld_t;

    localparam int COND_W = $bits(cond_fld_t);

endpackage

// File: rtl/dw_rotator.sv
// Logarithmic left rotator: one stage per amount bit.
module dw_rotator #(
    parameter int WIDTH = 64,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [SHW-1:0]   amt,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage [SHW+1];

    assign stage[0] = din;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int K = 1 << s;
        logic [WIDTH-1:0] rotated;
        assign rotated      = {stage[s][WIDTH-1-K:0], stage[s][WIDTH-1:WIDTH-K]};
        assign stage[s+1]   = amt[s] ? rotated : stage[s];
    end

    assign dout = stage[SHW];
endmodule

// File: rtl/dw_mask_gen.sv
// Marks the n positions that take fill bits: the low end for a left shift,
// the high end for a right shift.
module dw_mask_gen #(
    parameter int WIDTH = 64,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [SHW-1:0]   amt,
    input  logic             dir_right,
    output logic [WIDTH-1:0] fill_mask
);
    logic [WIDTH-1:0] low_mask;
    logic [WIDTH-1:0] high_mask;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign low_mask[i]            = (SHW+1)'(i) < {1'b0, amt};
        assign high_mask[WIDTH-1-i]   = low_mask[i];
    end

    assign fill_mask = dir_right ? high_mask : low_mask;
endmodule

// File: rtl/dw_cond_unit.sv
// Builds the condition field from the result and spill words.
module dw_cond_unit #(
    parameter int WIDTH = 64
) (
    input  logic                           rec_en,
    input  logic [WIDTH-1:0]               res_word,
    input  logic [WIDTH-1:0]               spill_word,
    output dw_funnel_pkg::cond_fld_t       cond
);
    import dw_funnel_pkg::*;

    logic is_zero;
    logic is_neg;

    assign is_zero = (res_word == '0);
    assign is_neg  = res_word[WIDTH-1];

    always_comb begin
        cond = '0;
        if (rec_en) begin
            cond.lt = is_neg;
            cond.gt = !is_neg && !is_zero;
            cond.eq = is_zero;
            cond.ov = |spill_word;
        end
    end
endmodule

// File: rtl/dw_funnel_shift.sv
module dw_funnel_shift #(
    parameter int WIDTH = 64,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic                              dir_right,
    input  logic [WIDTH-1:0]                  a_word,
    input  logic [WIDTH-1:0]                  b_word,
    input  logic [WIDTH-1:0]                  c_fill,
    input  logic                              rec_en,
    output logic [WIDTH-1:0]                  res_word,
    output logic [WIDTH-1:0]                  spill_word,
    output logic [dw_funnel_pkg::COND_W-1:0]  cond
);
    import dw_funnel_pkg::*;

    shift_dir_e       dir;
    logic [SHW-1:0]   amt;
    logic [SHW-1:0]   rot_amt;
    logic [WIDTH-1:0] rotated;
    logic [WIDTH-1:0] fill_mask;
    cond_fld_t        cond_s;
    logic             unused_b_hi;

    assign dir         = shift_dir_e'(dir_right);
    assign amt         = b_word[SHW-1:0];
    assign unused_b_hi = ^b_word[WIDTH-1:SHW];

    // A right shift by n is a left rotate by (WIDTH - n) mod WIDTH.
    always_comb begin
        unique case (dir)
            SHIFT_LEFT:  rot_amt = amt;
            SHIFT_RIGHT: rot_amt = '0 - amt;
            default:     rot_amt = amt;
        endcase
    end

    dw_rotator #(.WIDTH(WIDTH), .SHW(SHW)) u_rot (
        .din  (a_word),
        .amt  (rot_amt),
        .dout (rotated)
    );

    dw_mask_gen #(.WIDTH(WIDTH), .SHW(SHW)) u_mask (
        .amt       (amt),
        .dir_right (dir_right),
        .fill_mask (fill_mask)
    );

    // Wrapped bits land under the mask: they become the spill word,
    // and the fill word takes their place in the result.
    assign res_word   = (rotated & ~fill_mask) | (c_fill & fill_mask);
    assign spill_word = rotated & fill_mask;

    dw_cond_unit #(.WIDTH(WIDTH)) u_cond (
        .rec_en     (rec_en),
        .res_word   (res_word),
        .spill_word (spill_word),
        .cond       (cond_s)
    );

    assign cond = cond_s;
endmodule

// File: rtl/dw_funnel_shift_chk.sv
module dw_funnel_shift_chk #(
    parameter int WIDTH = 64,
    parameter int SHW   = $clog2(WIDTH)
) (
    input logic             dir_right,
    input logic [WIDTH-1:0] a_word,
    input logic [WIDTH-1:0] b_word,
    input logic [WIDTH-1:0] c_fill,
    input logic             rec_en,
    input logic [WIDTH-1:0] res_word,
    input logic [WIDTH-1:0] spill_word,
    input logic [3:0]       cond
);
    logic [SHW-1:0] n;
    logic           unused_c;

    assign n        = b_word[SHW-1:0];
    assign unused_c = ^c_fill | ^b_word[WIDTH-1:SHW];

    always_comb begin
        if (n == '0) begin
            p_zero_amount_r6: assert (res_word == a_word && spill_word == '0)
                else $error("R6 zero shift result or spill wrong");
        end
        if (!dir_right) begin
            // the pair {spill,res} shifted back down must give A alone
            p_left_pair_r2: assert (({spill_word, res_word} >> n) == {{WIDTH{1'b0}}, a_word})
                else $error("R2/R3 left pair does not recover A");
        end else begin
            p_right_pair_r4: assert (({res_word, spill_word} << n) == {a_word, {WIDTH{1'b0}}})
                else $error("R4/R5 right pair does not recover A");
        end
        if (rec_en) begin
            p_no_overflow_r7: assert (cond[0] == (spill_word != '0))
                else $error("R7 overflow bit disagrees with spill");
            p_one_sign_r8: assert ($countones(cond[3:1]) == 1)
                else $error("R8 sign bits not exclusive");
        end else begin
            p_cond_off_r9: assert (cond == 4'b0000)
                else $error("R9 condition field not cleared");
        end
    end
endmodule

bind dw_funnel_shift dw_funnel_shift_chk #(.WIDTH(WIDTH), .SHW(SHW)) u_chk (
    .dir_right  (dir_right),
    .a_word     (a_word),
    .b_word     (b_word),
    .c_fill     (c_fill),
    .rec_en     (rec_en),
    .res_word   (res_word),
    .spill_word (spill_word),
    .cond       (cond)
);

// File: tb/dw_funnel_shift_tb.sv
`timescale 1ns/1ps
module dw_funnel_shift_tb;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         dir_right;
    logic [W-1:0] a_word, b_word, c_fill;
    logic         rec_en;
    logic [W-1:0] res_word, spill_word;
    logic [3:0]   cond;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dw_funnel_shift u_dut (
        .dir_right (dir_right),
        .a_word    (a_word),
        .b_word    (b_word),
        .c_fill    (c_fill),
        .rec_en    (rec_en),
        .res_word  (res_word),
        .spill_word(spill_word),
        .cond      (cond)
    );

    function automatic logic [W-1:0] exp_res(bit r, logic [W-1:0] a, logic [5:0] n, logic [W-1:0] c);
        logic [2*W-1:0] full;
        logic [W-1:0]   ones = '1;
        if (!r) begin
            full = {{W{1'b0}}, a} << n;
            return full[W-1:0] | (c & ((ones << n) ^ ones));
        end
        full = {a, {W{1'b0}}} >> n;
        return full[2*W-1:W] | (c & ~(ones >> n));
    endfunction

    function automatic logic [W-1:0] exp_spill(bit r, logic [W-1:0] a, logic [5:0] n);
        logic [2*W-1:0] full;
        if (!r) begin
            full = {{W{1'b0}}, a} << n;
            return full[2*W-1:W];
        end
        full = {a, {W{1'b0}}} >> n;
        return full[W-1:0];
    endfunction

    function automatic logic [3:0] exp_cond(bit rec, logic [W-1:0] r, logic [W-1:0] s);
        if (!rec) return 4'b0000;
        return {$signed(r) < 0, $signed(r) > 0, r == '0, s != '0};
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(bit r, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c, bit rec);
        @(posedge clk);
        dir_right = r; a_word = a; b_word = b; c_fill = c; rec_en = rec;
        #2;
    endtask

    // drive one vector and compare all three outputs
    task automatic run_vec(string req, bit r, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c, bit rec);
        logic [W-1:0] er, es;
        apply(r, a, b, c, rec);
        er = exp_res(r, a, b[5:0], c);
        es = exp_spill(r, a, b[5:0]);
        check({req, " res"}, res_word, er);
        check({req, " spill"}, spill_word, es);
        check({req, " cond"}, {60'b0, cond}, {60'b0, exp_cond(rec, er, es)});
    endtask

    task automatic t_reset();
        apply(1'b0, '0, '0, '0, 1'b0);
        check("reset R9 res", res_word, '0);
        check("reset R9 spill", spill_word, '0);
        check("reset R9 cond", {60'b0, cond}, '0);
    endtask

    task automatic t_amount_mask();   // R1
        run_vec("R1 left", 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FF05, 64'h5555_5555_5555_5555, 1'b1);
        run_vec("R1 right", 1'b1, 64'h0123_4567_89AB_CDEF, 64'h8000_0000_0000_0C4A, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1);
    endtask

    task automatic t_left();          // R2 R3
        run_vec("R2/R3 n=4", 1'b0, 64'hF00D_CAFE_1234_5678, 64'd4, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        run_vec("R2/R3 n=1", 1'b0, 64'h8000_0000_0000_0001, 64'd1, 64'h0000_0000_0000_0001, 1'b1);
        run_vec("R2/R3 n=63", 1'b0, 64'hDEAD_BEEF_0BAD_F00D, 64'd63, 64'h7FFF_FFFF_FFFF_FFFE, 1'b1);
        run_vec("R2/R3 n=32", 1'b0, 64'h0000_0000_FFFF_0000, 64'd32, 64'h1111_2222_3333_4444, 1'b0);
    endtask

    task automatic t_right();         // R4 R5
        run_vec("R4/R5 n=8", 1'b1, 64'hF00D_CAFE_1234_5678, 64'd8, 64'h0000_0000_0000_0000, 1'b1);
        run_vec("R4/R5 n=1", 1'b1, 64'h0000_0000_0000_0001, 64'd1, 64'h8000_0000_0000_0000, 1'b1);
        run_vec("R4/R5 n=63", 1'b1, 64'hDEAD_BEEF_0BAD_F00D, 64'd63, 64'h1234_5678_9ABC_DEF0, 1'b1);
        run_vec("R4/R5 n=17", 1'b1, 64'h0000_0000_0000_0000, 64'd17, 64'hFFFF_0000_FFFF_0000, 1'b1);
    endtask

    task automatic t_zero();          // R6
        apply(1'b0, 64'hA5A5_5A5A_0F0F_F0F0, 64'h40, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        check("R6 left res", res_word, 64'hA5A5_5A5A_0F0F_F0F0);
        check("R6 left spill", spill_word, '0);
        apply(1'b1, 64'hA5A5_5A5A_0F0F_F0F0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        check("R6 right res", res_word, 64'hA5A5_5A5A_0F0F_F0F0);
        check("R6 right spill", spill_word, '0);
    endtask

    task automatic t_cond();          // R7 R8
        // result zero, spill nonzero: EQ and OV
        apply(1'b0, 64'hFF00_0000_0000_0000, 64'd8, 64'h0, 1'b1);
        check("R7/R8 eq+ov", {60'b0, cond}, {60'b0, 4'b0011});
        // result negative, no spill: LT only
        apply(1'b1, 64'h0000_0000_0000_0100, 64'd8, 64'hFF00_0000_0000_0000, 1'b1);
        check("R8 lt", {60'b0, cond}, {60'b0, 4'b1000});
        // result positive, spill nonzero: GT and OV
        apply(1'b1, 64'h0000_0000_0000_0101, 64'd8, 64'h0, 1'b1);
        check("R7/R8 gt+ov", {60'b0, cond}, {60'b0, 4'b0101});
    endtask

    task automatic t_rec_off();       // R9
        apply(1'b0, 64'hFF00_0000_0000_0000, 64'd8, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        check("R9 cond off", {60'b0, cond}, '0);
        check("R9 res unaffected", res_word, 64'h0000_0000_0000_00FF);
    endtask

    task automatic t_chain();         // R10
        logic [3*W-1:0] x, ref_v, got;
        logic [W-1:0]   carry;
        logic [5:0]     n = 6'd13;
        x = {64'h8123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'hC0DE_D00D_1357_9BDF};
        carry = '0;
        for (int i = 0; i < 3; i++) begin
            apply(1'b0, x[i*W +: W], {58'b0, n}, carry, 1'b0);
            got[i*W +: W] = res_word;
            carry = spill_word;
        end
        ref_v = x << n;
        check("R10 left low", got[W-1:0], ref_v[W-1:0]);
        check("R10 left mid", got[2*W-1:W], ref_v[2*W-1:W]);
        check("R10 left top", got[3*W-1:2*W], ref_v[3*W-1:2*W]);
        check("R10 left out", carry, {51'b0, x[3*W-1 -: 13]});
        carry = '0;
        for (int i = 2; i >= 0; i--) begin
            apply(1'b1, x[i*W +: W], {58'b0, n}, carry, 1'b0);
            got[i*W +: W] = res_word;
            carry = spill_word;
        end
        ref_v = x >> n;
        check("R10 right low", got[W-1:0], ref_v[W-1:0]);
        check("R10 right mid", got[2*W-1:W], ref_v[2*W-1:W]);
        check("R10 right top", got[3*W-1:2*W], ref_v[3*W-1:2*W]);
        check("R10 right out", carry, {x[12:0], 51'b0});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_amount_mask();
        t_left();
        t_right();
        t_zero();
        t_cond();
        t_rec_off();
        t_chain();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule